// File: doc/BRIEF.md
# Sleep Mode Clock Domain Controller

This block decides which clock domains of a small microcontroller keep running while the processor sleeps. Software picks one of six sleep modes with a 3-bit select and arms sleeping with an enable bit. When the processor then issues a one-cycle sleep strobe, the controller stores the mode and drops the enables of the domains that mode shuts down. The seven domains are the processor core, the data SRAM, the I/O peripherals (timers and serial port), the converter, the asynchronous timer, the main oscillator and the interrupt logic.

A wake event arriving on the interrupt input brings every domain back. If the stored mode had stopped the main oscillator, the core clock is held off for a programmable number of start-up cycles. In that interval every other domain runs. The two standby modes keep the oscillator alive, so they skip this wait. A synchronous hardware reset returns the controller to the awake state from any state. The analog oscillator, the peripherals and register retention are not part of the block. Each one appears only as an enable output.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, all seven domain enables are high.
- R2: A sleep strobe while the arm bit is low is ignored. All enables stay high and the core keeps running.
- R3: Idle (select 000) lowers only the core enable, on the clock edge that samples the strobe.
- R4: Converter-quiet mode (select 001) lowers the core, SRAM and I/O enables and keeps the converter, asynchronous timer, oscillator and interrupt enables high.
- R5: Full power-off (select 010) lowers every enable, and they stay low until a wake event or a reset.
- R6: Timer-save mode (select 011) keeps only the asynchronous timer enable high.
- R7: Standby (select 110) keeps only the oscillator enable high.
- R8: Extended standby (select 111) keeps the oscillator and asynchronous timer enables high.
- R9: The unused selects 100 and 101 act as Idle.
- R10: On wake from select 010 or 011 with a start-up count N > 0, the core enable stays low for exactly N cycles, counting from the waking edge. All other enables are high during that interval.
- R11: On wake from select 000, 001, 110 or 111, all enables are high on the edge that samples the wake input.
- R12: Reset while sleeping or while waiting for start-up raises all enables on the next edge.
- R13: The mode is captured at the strobe. Changing the select while asleep has no effect on the enables.
- R14: A start-up count of zero makes a wake from select 010 or 011 immediate, as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mode_sel | input | 3 | Sleep mode select |
| sleep_arm | input | 1 | Permits a sleep strobe to take effect |
| sleep_req | input | 1 | One-cycle sleep strobe from the core |
| wake_irq | input | 1 | Wake event from the interrupt system |
| startup_len | input | CNT_W | Oscillator start-up cycles after a power-off wake |
| en_cpu | output | 1 | Core clock enable |
| en_sram | output | 1 | SRAM clock enable |
| en_io | output | 1 | I/O peripheral clock enable |
| en_adc | output | 1 | Converter clock enable |
| en_async | output | 1 | Asynchronous timer enable |
| en_osc | output | 1 | Main oscillator enable |
| en_irq | output | 1 | Interrupt logic clock enable |

## Verification
A wrong stored mode or a wrong state shows at the enable ports on the edge right after the strobe or the wake event. No output is hidden behind a pipeline. A start-up counter that is off by one shows as a core enable that rises one cycle early or late. The bench therefore samples every cycle of the wait. A mode that is not held while asleep shows as soon as the select changes, because the enables are recomputed on every edge.

// File: rtl/sleep_clk_pkg.sv
package sleep_clk_pkg;

  localparam int NUM_DOM = 7;

  // Domain bit positions inside the enable vector
  localparam int D_CPU   = 0;
  localparam int D_SRAM  = 1;
  localparam int D_IO    = 2;
  localparam int D_ADC   = 3;
  localparam int D_ASYNC = 4;
  localparam int D_OSC   = 5;
  localparam int D_IRQ   = 6;

  typedef logic [NUM_DOM-1:0] dom_vec_t;

  typedef enum logic [2:0] {
    M_IDLE     = 3'b000,
    M_ADC_QUIET= 3'b001,
    M_POWEROFF = 3'b010,
    M_TIMERSAVE= 3'b011,
    M_STANDBY  = 3'b110,
    M_EXT_STBY = 3'b111
  } sleep_mode_t;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_STARTUP = 2'd2
  } ctrl_state_t;

  localparam dom_vec_t ALL_ON     = '1;
  localparam dom_vec_t STARTUP_EN = ~(dom_vec_t'(1) << D_CPU);

endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_clk_pkg::*;
(
  input  logic [2:0] mode,
  output dom_vec_t   keep_mask,
  output logic       osc_stops
);

  always_comb begin
    keep_mask = '0;
    osc_stops = 1'b0;
    case (mode)
      M_ADC_QUIET: begin
        keep_mask[D_ADC]   = 1'b1;
        keep_mask[D_ASYNC] = 1'b1;
        keep_mask[D_OSC]   = 1'b1;
        keep_mask[D_IRQ]   = 1'b1;
      end
      M_POWEROFF: begin
        osc_stops = 1'b1;
      end
      M_TIMERSAVE: begin
        keep_mask[D_ASYNC] = 1'b1;
        osc_stops          = 1'b1;
      end
      M_STANDBY: begin
        keep_mask[D_OSC] = 1'b1;
      end
      M_EXT_STBY: begin
        keep_mask[D_OSC]   = 1'b1;
        keep_mask[D_ASYNC] = 1'b1;
      end
      default: begin
        // Idle and the unused selects: only the core stops
        keep_mask        = ALL_ON;
        keep_mask[D_CPU] = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sleep_startup_timer.sv
module sleep_startup_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_clk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_sel,
  input  logic             sleep_arm,
  input  logic             sleep_req,
  input  logic             wake_irq,
  input  logic [CNT_W-1:0] startup_len,
  output logic             en_cpu,
  output logic             en_sram,
  output logic             en_io,
  output logic             en_adc,
  output logic             en_async,
  output logic             en_osc,
  output logic             en_irq
);

  ctrl_state_t state_q, state_d;
  logic [2:0]  mode_q, mode_d;
  dom_vec_t    en_q, en_d;
  dom_vec_t    keep_mask;
  logic        osc_stops;
  logic        tmr_load, tmr_last;

  sleep_mode_decode u_decode (
    .mode      (mode_d),
    .keep_mask (keep_mask),
    .osc_stops (osc_stops)
  );

  sleep_startup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (startup_len),
    .last     (tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    tmr_load = 1'b0;
    case (state_q)
      ST_AWAKE: begin
        if (sleep_req && sleep_arm) begin
          state_d = ST_SLEEP;
          mode_d  = mode_sel;
        end
      end
      ST_SLEEP: begin
        if (wake_irq) begin
          if (osc_stops && (startup_len != '0)) begin
            state_d  = ST_STARTUP;
            tmr_load = 1'b1;
          end else begin
            state_d = ST_AWAKE;
          end
        end
      end
      ST_STARTUP: begin
        if (tmr_last) state_d = ST_AWAKE;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_SLEEP:   en_d = keep_mask;
      ST_STARTUP: en_d = STARTUP_EN;
      default:    en_d = ALL_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_AWAKE;
      mode_q  <= 3'b000;
      en_q    <= ALL_ON;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
    end
  end

  assign en_cpu   = en_q[D_CPU];
  assign en_sram  = en_q[D_SRAM];
  assign en_io    = en_q[D_IO];
  assign en_adc   = en_q[D_ADC];
  assign en_async = en_q[D_ASYNC];
  assign en_osc   = en_q[D_OSC];
  assign en_irq   = en_q[D_IRQ];

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic sleep_arm,
  input logic sleep_req,
  input logic wake_irq,
  input logic en_cpu,
  input logic en_sram,
  input logic en_io,
  input logic en_adc,
  input logic en_async,
  input logic en_osc,
  input logic en_irq
);

  logic [6:0] en_all;
  logic [5:0] en_rest;
  assign en_rest = {en_irq, en_osc, en_async, en_adc, en_io, en_sram};
  assign en_all  = {en_rest, en_cpu};

  // R12: reset always brings every domain back
  assert_reset_all_on_R12: assert property (@(posedge clk)
    rst |=> (&en_all));

  // R2: disarmed strobe leaves the awake state untouched
  assert_disarmed_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    ((&en_all) && sleep_req && !sleep_arm) |=> (&en_all));

  // R5: full power-off holds until a wake event
  assert_poweroff_holds_R5: assert property (@(posedge clk) disable iff (rst)
    ((en_all == 7'd0) && !wake_irq) |=> (en_all == 7'd0));

  // R10: once only the core is held off, the other domains stay on
  assert_startup_others_on_R10: assert property (@(posedge clk) disable iff (rst)
    (!en_cpu && (&en_rest)) |=> (&en_rest));

  // R11: the core clock only restarts together with every other domain
  assert_cpu_restart_all_on_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(en_cpu) |-> (&en_all));

endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_arm (sleep_arm),
  .sleep_req (sleep_req),
  .wake_irq  (wake_irq),
  .en_cpu    (en_cpu),
  .en_sram   (en_sram),
  .en_io     (en_io),
  .en_adc    (en_adc),
  .en_async  (en_async),
  .en_osc    (en_osc),
  .en_irq    (en_irq)
);

// File: tb/test_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module test_sleep_clk_ctrl;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       mode_sel = 3'b000;
  logic             sleep_arm = 1'b0;
  logic             sleep_req = 1'b0;
  logic             wake_irq = 1'b0;
  logic [CNT_W-1:0] startup_len = '0;
  logic en_cpu, en_sram, en_io, en_adc, en_async, en_osc, en_irq;

  int n_checks = 0;
  int n_fail   = 0;

  // {irq, osc, async, adc, io, sram, cpu}
  localparam logic [6:0] P_ALL   = 7'b1111111;
  localparam logic [6:0] P_IDLE  = 7'b1111110;
  localparam logic [6:0] P_ADCQ  = 7'b1111000;
  localparam logic [6:0] P_OFF   = 7'b0000000;
  localparam logic [6:0] P_TSAVE = 7'b0010000;
  localparam logic [6:0] P_STBY  = 7'b0100000;
  localparam logic [6:0] P_EXT   = 7'b0110000;

  always #5 clk = ~clk;

  sleep_clk_ctrl #(.CNT_W(CNT_W)) i_sleep_clk_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sleep_arm(sleep_arm),
    .sleep_req(sleep_req), .wake_irq(wake_irq), .startup_len(startup_len),
    .en_cpu(en_cpu), .en_sram(en_sram), .en_io(en_io), .en_adc(en_adc),
    .en_async(en_async), .en_osc(en_osc), .en_irq(en_irq)
  );

  function automatic logic [6:0] en_now();
    return {en_irq, en_osc, en_async, en_adc, en_io, en_sram, en_cpu};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    n_checks++;
    if (en_now() !== exp) begin
      n_fail++;
      $display("FAIL %s: enables actual %b expected %b", req, en_now(), exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sleep_req = 1'b0; wake_irq = 1'b0;
    tick();
    rst = 1'b0;
  endtask

  task automatic go_sleep(input logic [2:0] m);
    mode_sel = m; sleep_arm = 1'b1; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  task automatic wake();
    wake_irq = 1'b1;
    tick();
    wake_irq = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", P_ALL);
  endtask

  task automatic t_disarmed();
    do_reset();
    mode_sel = 3'b010; sleep_arm = 1'b0; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    check("R2", P_ALL);
    tick(); tick();
    check("R2", P_ALL);
  endtask

  task automatic t_mode(input logic [2:0] m, input logic [6:0] pat, input string req,
                        input string wreq);
    do_reset();
    startup_len = '0;
    go_sleep(m);
    check(req, pat);
    tick(); tick();
    check(req, pat);
    wake();
    check(wreq, P_ALL);
  endtask

  task automatic t_startup(input logic [2:0] m, input logic [6:0] pat, input int n);
    do_reset();
    startup_len = CNT_W'(n);
    go_sleep(m);
    check("R10", pat);
    wake();
    for (int k = 0; k < n; k++) begin
      check("R10", P_IDLE);
      if (k < n - 1) tick();
    end
    tick();
    check("R10", P_ALL);
    startup_len = '0;
  endtask

  task automatic t_latched();
    do_reset();
    go_sleep(3'b010);
    mode_sel = 3'b000;
    tick(); tick();
    check("R13", P_OFF);
    mode_sel = 3'b111;
    tick();
    check("R13", P_OFF);
    wake();
    check("R13", P_ALL);
  endtask

  task automatic t_reset_asleep();
    do_reset();
    go_sleep(3'b010);
    check("R12", P_OFF);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R12", P_ALL);
    startup_len = CNT_W'(6);
    go_sleep(3'b011);
    wake();
    tick();
    check("R12", P_IDLE);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R12", P_ALL);
    tick(); tick(); tick(); tick(); tick(); tick();
    check("R12", P_ALL);
    startup_len = '0;
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_disarmed();
    t_mode(3'b000, P_IDLE,  "R3", "R11");
    t_mode(3'b001, P_ADCQ,  "R4", "R11");
    t_mode(3'b010, P_OFF,   "R5", "R14");
    t_mode(3'b011, P_TSAVE, "R6", "R14");
    t_mode(3'b110, P_STBY,  "R7", "R11");
    t_mode(3'b111, P_EXT,   "R8", "R11");
    t_mode(3'b100, P_IDLE,  "R9", "R11");
    t_mode(3'b101, P_IDLE,  "R9", "R11");
    t_startup(3'b010, P_OFF, 5);
    t_startup(3'b011, P_TSAVE, 1);
    t_startup(3'b010, P_OFF, 3);
    t_latched();
    t_reset_asleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule